// File: doc/BRIEF.md
# Peer Delay Request Ingress Capture

This block keeps the arrival time and correction value of the last accepted peer-delay request seen on one port. A peer-delay response can then be built from these values. Upstream logic delivers three things: the parsed PTP header fields as a one-cycle strobe, the captured ingress timestamp as a one-cycle strobe, and the frame status at the end-of-frame strobe. The block holds header and timestamp data in a staging area while the frame is in progress. It copies them into the visible registers in one cycle, at the end-of-frame strobe, and only when every enabled check has passed. A frame that fails leaves the registers exactly as they were.

Software sees four 32-bit words through a simple read/write port: ingress seconds, ingress nanoseconds, correction high word and correction low word. Software may write any of them directly, for example to preload values before it sends a response. Bit 31 of the nanoseconds word is the auto-update enable. While this bit is clear the hardware never loads the registers. No per-message-type receive mask takes part in the decision.

Top module: `pdreq_capture`

## Requirements
- R1: After reset all four words read as zero, so auto-update starts disabled.
- R2: Word addresses are 0 = seconds, 1 = nanoseconds, 2 = correction bits 63:32, 3 = correction bits 31:0. A write sets the addressed word. In word 1, bit 31 is the auto-update enable, bits 29:0 hold nanoseconds, and bit 30 always reads 0.
- R3: With auto-update set, a frame that passes every check updates all four words. The frame is a start strobe, then a header strobe with messageType 0x2, then a timestamp strobe, then the end strobe. The new values are readable in the cycle after the end strobe.
- R4: With auto-update clear, no frame changes any word.
- R5: A header whose messageType is not 0x2 is never captured.
- R6: When the version check is enabled, the header version must equal the configured version. Version 1 headers are never captured, whether or not the check is enabled.
- R7: When the domain check is enabled, the header domain must equal the configured domain.
- R8: When the alternate-master check is enabled, the header flag must equal the configured flag.
- R9: When the FCS check is enabled, a bad FCS at end of frame blocks the update. When the UDP check is enabled, a bad checksum blocks the update only for IPv4/IPv6 frames.
- R10: A frame that fails, or lacks a header strobe or a timestamp strobe before its end strobe, leaves all words unchanged.
- R11: When a register write and a hardware commit fall in the same cycle, the commit wins and the whole write is dropped. A commit never alters the auto-update bit.
- R12: A start-of-frame strobe discards any header and timestamp staged earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_sof | input | 1 | Start-of-frame strobe |
| frm_eof | input | 1 | End-of-frame strobe |
| eof_fcs_ok | input | 1 | FCS good, valid with frm_eof |
| eof_udp_ok | input | 1 | UDP checksum good, valid with frm_eof |
| eof_is_ip | input | 1 | Frame is IPv4/IPv6 encapsulated, valid with frm_eof |
| hdr_valid | input | 1 | Parsed header strobe |
| hdr_msg_type | input | 4 | messageType field |
| hdr_version | input | 4 | versionPTP field |
| hdr_domain | input | 8 | domainNumber field |
| hdr_alt_master | input | 1 | alternateMasterFlag |
| hdr_corr | input | 64 | correctionField |
| ts_valid | input | 1 | Ingress timestamp strobe |
| ts_sec | input | 32 | Ingress seconds |
| ts_ns | input | 30 | Ingress nanoseconds |
| cfg_ver_chk_en | input | 1 | Enable version check |
| cfg_version | input | 4 | Expected version |
| cfg_dom_chk_en | input | 1 | Enable domain check |
| cfg_domain | input | 8 | Expected domain |
| cfg_alt_chk_en | input | 1 | Enable alternate-master check |
| cfg_alt_master | input | 1 | Expected alternate-master flag |
| cfg_fcs_chk_en | input | 1 | Enable FCS check |
| cfg_udp_chk_en | input | 1 | Enable UDP checksum check |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
The bench runs frames that are identical except for one failing check: a wrong messageType, a version mismatch, a version 1 header, a wrong domain, a wrong alternate flag, a bad FCS, and a bad checksum on an IP frame. A design that ignored any one of these would overwrite the saved values. A bad checksum on a non-IP frame must still commit; a design that applied the checksum test to every frame would wrongly keep the old values. A register write placed on the end-of-frame cycle targets the nanoseconds word with the auto bit clear. A design that let software win, or that let the commit clear the auto bit, would then show the written word or a disabled auto bit. The bench also sends an aborted frame followed by a new start strobe and a frame without a header. A design that did not clear the staging area would commit the stale header.

// File: rtl/pdreq_pkg.sv
`timescale 1ns/1ps
package pdreq_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SEC_W    = 32;
    localparam int unsigned NS_W     = 30;
    localparam int unsigned CORR_W   = 64;
    localparam int unsigned MSG_W    = 4;
    localparam int unsigned VER_W    = 4;
    localparam int unsigned DOM_W    = 8;
    localparam int unsigned REG_NUM  = 4;
    localparam int unsigned ADDR_W   = $clog2(REG_NUM);
    localparam int unsigned CF_WORDS = CORR_W / WORD_W;
    localparam int unsigned AUTO_BIT = WORD_W - 1;
    localparam int unsigned PAD_W    = WORD_W - NS_W - 1;

    localparam logic [MSG_W-1:0] MSG_PEER_REQ = MSG_W'(2);
    localparam logic [VER_W-1:0] VER_LEGACY   = VER_W'(1);

    localparam logic [ADDR_W-1:0] ADR_SEC   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_NS    = ADDR_W'(1);
    localparam int unsigned       CF_BASE   = 2;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [CORR_W-1:0] corr;
    } cap_t;

    typedef struct packed {
        logic hdr_seen;
        logic hdr_ok;
        logic ts_seen;
        cap_t data;
    } stage_t;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic              auto_en;
        logic [NS_W-1:0]   ns;
        logic [CORR_W-1:0] corr;
    } regs_t;
endpackage

// File: rtl/pdreq_qualify.sv
`timescale 1ns/1ps
module pdreq_qualify
    import pdreq_pkg::*;
(
    input  logic [MSG_W-1:0] msg_type,
    input  logic [VER_W-1:0] version,
    input  logic [DOM_W-1:0] domain,
    input  logic             alt_master,
    input  logic             ver_chk_en,
    input  logic [VER_W-1:0] cfg_version,
    input  logic             dom_chk_en,
    input  logic [DOM_W-1:0] cfg_domain,
    input  logic             alt_chk_en,
    input  logic             cfg_alt_master,
    output logic             hdr_pass
);
    logic type_ok, legacy, ver_ok, dom_ok, alt_ok;

    always_comb begin
        type_ok  = (msg_type == MSG_PEER_REQ);
        legacy   = (version == VER_LEGACY);
        ver_ok   = !ver_chk_en || (version == cfg_version);
        dom_ok   = !dom_chk_en || (domain == cfg_domain);
        alt_ok   = !alt_chk_en || (alt_master == cfg_alt_master);
        hdr_pass = type_ok && !legacy && ver_ok && dom_ok && alt_ok;
    end

    always_comb begin
        if (legacy) assert_legacy_reject_R6: assert (!hdr_pass);
    end
endmodule

// File: rtl/pdreq_stage.sv
`timescale 1ns/1ps
module pdreq_stage
    import pdreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic              fcs_ok,
    input  logic              udp_ok,
    input  logic              is_ip,
    input  logic              fcs_chk_en,
    input  logic              udp_chk_en,
    input  logic              hdr_valid,
    input  logic              hdr_pass,
    input  logic [CORR_W-1:0] hdr_corr,
    input  logic              ts_valid,
    input  logic [SEC_W-1:0]  ts_sec,
    input  logic [NS_W-1:0]   ts_ns,
    input  logic              auto_en,
    output logic              commit,
    output cap_t              commit_data
);
    stage_t st_d, st_q;
    logic   integ_ok;

    always_comb begin
        st_d = st_q;
        if (hdr_valid) begin
            st_d.hdr_seen  = 1'b1;
            st_d.hdr_ok    = hdr_pass;
            st_d.data.corr = hdr_corr;
        end
        if (ts_valid) begin
            st_d.ts_seen  = 1'b1;
            st_d.data.sec = ts_sec;
            st_d.data.ns  = ts_ns;
        end
        if (sof || eof) begin
            st_d.hdr_seen = 1'b0;
            st_d.hdr_ok   = 1'b0;
            st_d.ts_seen  = 1'b0;
        end

        integ_ok = (!fcs_chk_en || fcs_ok) &&
                   (!udp_chk_en || !is_ip || udp_ok);
        commit = eof && auto_en && st_q.hdr_seen && st_q.hdr_ok &&
                 st_q.ts_seen && integ_ok;
        commit_data = st_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_frame_bound_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sof || eof) |=> (!st_q.hdr_seen && !st_q.ts_seen));
    assert_commit_after_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hdr_seen) |-> $past(hdr_valid));
endmodule

// File: rtl/pdreq_regfile.sv
`timescale 1ns/1ps
module pdreq_regfile
    import pdreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cap_t              commit_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              auto_en
);
    regs_t rf_d, rf_q;
    logic [WORD_W-1:0] words [REG_NUM];

    always_comb begin
        rf_d = rf_q;
        if (commit) begin
            rf_d.sec  = commit_data.sec;
            rf_d.ns   = commit_data.ns;
            rf_d.corr = commit_data.corr;
        end else if (wr_en) begin
            if (addr == ADR_SEC) rf_d.sec = wdata[SEC_W-1:0];
            if (addr == ADR_NS) begin
                rf_d.auto_en = wdata[AUTO_BIT];
                rf_d.ns      = wdata[NS_W-1:0];
            end
            for (int g = 0; g < CF_WORDS; g++) begin
                if (addr == ADDR_W'(CF_BASE + g))
                    rf_d.corr[CORR_W-1-g*WORD_W -: WORD_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign words[ADR_SEC] = rf_q.sec;
    assign words[ADR_NS]  = {rf_q.auto_en, {PAD_W{1'b0}}, rf_q.ns};
    for (genvar g = 0; g < CF_WORDS; g++) begin : g_cf_word
        assign words[CF_BASE+g] = rf_q.corr[CORR_W-1-g*WORD_W -: WORD_W];
    end

    assign rdata   = words[addr];
    assign auto_en = rf_q.auto_en;

    assert_hw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (rf_q.sec == $past(commit_data.sec) &&
                    rf_q.ns == $past(commit_data.ns) &&
                    rf_q.corr == $past(commit_data.corr)));
    assert_auto_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> $stable(rf_q.auto_en));
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !wr_en) |=> $stable(rf_q));
    assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !commit && addr == ADR_SEC) |=> rf_q.sec == $past(wdata));
endmodule

// File: rtl/pdreq_capture.sv
`timescale 1ns/1ps
module pdreq_capture
    import pdreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_sof,
    input  logic              frm_eof,
    input  logic              eof_fcs_ok,
    input  logic              eof_udp_ok,
    input  logic              eof_is_ip,
    input  logic              hdr_valid,
    input  logic [MSG_W-1:0]  hdr_msg_type,
    input  logic [VER_W-1:0]  hdr_version,
    input  logic [DOM_W-1:0]  hdr_domain,
    input  logic              hdr_alt_master,
    input  logic [CORR_W-1:0] hdr_corr,
    input  logic              ts_valid,
    input  logic [SEC_W-1:0]  ts_sec,
    input  logic [NS_W-1:0]   ts_ns,
    input  logic              cfg_ver_chk_en,
    input  logic [VER_W-1:0]  cfg_version,
    input  logic              cfg_dom_chk_en,
    input  logic [DOM_W-1:0]  cfg_domain,
    input  logic              cfg_alt_chk_en,
    input  logic              cfg_alt_master,
    input  logic              cfg_fcs_chk_en,
    input  logic              cfg_udp_chk_en,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    logic hdr_pass, commit, auto_en;
    cap_t commit_data;

    pdreq_qualify u_qualify (
        .msg_type       (hdr_msg_type),
        .version        (hdr_version),
        .domain         (hdr_domain),
        .alt_master     (hdr_alt_master),
        .ver_chk_en     (cfg_ver_chk_en),
        .cfg_version    (cfg_version),
        .dom_chk_en     (cfg_dom_chk_en),
        .cfg_domain     (cfg_domain),
        .alt_chk_en     (cfg_alt_chk_en),
        .cfg_alt_master (cfg_alt_master),
        .hdr_pass       (hdr_pass)
    );

    pdreq_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof         (frm_sof),
        .eof         (frm_eof),
        .fcs_ok      (eof_fcs_ok),
        .udp_ok      (eof_udp_ok),
        .is_ip       (eof_is_ip),
        .fcs_chk_en  (cfg_fcs_chk_en),
        .udp_chk_en  (cfg_udp_chk_en),
        .hdr_valid   (hdr_valid),
        .hdr_pass    (hdr_pass),
        .hdr_corr    (hdr_corr),
        .ts_valid    (ts_valid),
        .ts_sec      (ts_sec),
        .ts_ns       (ts_ns),
        .auto_en     (auto_en),
        .commit      (commit),
        .commit_data (commit_data)
    );

    pdreq_regfile u_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_data (commit_data),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .auto_en     (auto_en)
    );

    assert_commit_at_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (frm_eof && auto_en));
    assert_no_update_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !reg_wr_en) |=> $stable(reg_rdata) || !$stable(reg_addr));
endmodule

// File: tb/tb_pdreq_capture.sv
`timescale 1ns/1ps
module tb_pdreq_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_sof = 0, frm_eof = 0, eof_fcs_ok = 1, eof_udp_ok = 1, eof_is_ip = 1;
    logic        hdr_valid = 0, hdr_alt_master = 0, ts_valid = 0;
    logic [3:0]  hdr_msg_type = 0, hdr_version = 0, cfg_version = 0;
    logic [7:0]  hdr_domain = 0, cfg_domain = 0;
    logic [63:0] hdr_corr = 0;
    logic [31:0] ts_sec = 0;
    logic [29:0] ts_ns = 0;
    logic        cfg_ver_chk_en = 0, cfg_dom_chk_en = 0, cfg_alt_chk_en = 0, cfg_alt_master = 0;
    logic        cfg_fcs_chk_en = 0, cfg_udp_chk_en = 0;
    logic        reg_wr_en = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // frame field settings used by the frame task
    logic [3:0]  f_msg = 4'h2, f_ver = 4'h2;
    logic [7:0]  f_dom = 8'h05;
    logic        f_alt = 0, f_fcs = 1, f_udp = 1, f_ip = 1;
    logic [63:0] f_corr = 0;
    logic [31:0] f_sec = 0;
    logic [29:0] f_ns = 0;

    always #2.5 clk = ~clk;

    pdreq_capture dut (.*);

    // behavioural reference model
    logic [31:0] m_sec; logic [29:0] m_ns; logic m_auto; logic [63:0] m_corr;
    logic m_hdr, m_ok, m_ts; logic [31:0] m_ssec; logic [29:0] m_sns; logic [63:0] m_scorr;
    logic m_go, m_pass;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec <= 0; m_ns <= 0; m_auto <= 0; m_corr <= 0;
            m_hdr <= 0; m_ok <= 0; m_ts <= 0; m_ssec <= 0; m_sns <= 0; m_scorr <= 0;
        end else begin
            m_go = frm_eof && m_auto && m_hdr && m_ok && m_ts &&
                   (!cfg_fcs_chk_en || eof_fcs_ok) &&
                   (!cfg_udp_chk_en || !eof_is_ip || eof_udp_ok);
            m_pass = (hdr_msg_type == 4'h2) && (hdr_version != 4'h1) &&
                     (!cfg_ver_chk_en || hdr_version == cfg_version) &&
                     (!cfg_dom_chk_en || hdr_domain == cfg_domain) &&
                     (!cfg_alt_chk_en || hdr_alt_master == cfg_alt_master);
            if (m_go) begin
                m_sec <= m_ssec; m_ns <= m_sns; m_corr <= m_scorr;
            end else if (reg_wr_en) begin
                case (reg_addr)
                    2'd0: m_sec <= reg_wdata;
                    2'd1: begin m_auto <= reg_wdata[31]; m_ns <= reg_wdata[29:0]; end
                    2'd2: m_corr[63:32] <= reg_wdata;
                    default: m_corr[31:0] <= reg_wdata;
                endcase
            end
            if (hdr_valid) m_scorr <= hdr_corr;
            if (ts_valid) begin m_ssec <= ts_sec; m_sns <= ts_ns; end
            if (frm_sof || frm_eof) begin
                m_hdr <= 0; m_ok <= 0; m_ts <= 0;
            end else begin
                if (hdr_valid) begin m_hdr <= 1; m_ok <= m_pass; end
                if (ts_valid) m_ts <= 1;
            end
        end
    end

    function automatic logic [31:0] model_word(input logic [1:0] a);
        case (a)
            2'd0: return m_sec;
            2'd1: return {m_auto, 1'b0, m_ns};
            2'd2: return m_corr[63:32];
            default: return m_corr[31:0];
        endcase
    endfunction

    // per-cycle comparison against the model (R10 covers stability across frames)
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            n_checks++;
            if (reg_rdata !== model_word(reg_addr)) begin
                n_fail++;
                $display("FAIL R10 model addr %0d: actual %h expected %h",
                         reg_addr, reg_rdata, model_word(reg_addr));
            end
        end
    end

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a;
        @(posedge clk); #1;
        n_checks++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [31:0] s, input logic [31:0] n,
                             input logic [31:0] hi, input logic [31:0] lo);
        read_chk(tag, 2'd0, s);
        read_chk(tag, 2'd1, n);
        read_chk(tag, 2'd2, hi);
        read_chk(tag, 2'd3, lo);
    endtask

    task automatic sw_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic frame(input bit has_hdr, input bit has_ts, input bit do_eof,
                         input bit wr, input logic [1:0] wa, input logic [31:0] wd);
        @(negedge clk); frm_sof = 1;
        @(negedge clk); frm_sof = 0;
        if (has_hdr) begin
            hdr_valid = 1; hdr_msg_type = f_msg; hdr_version = f_ver;
            hdr_domain = f_dom; hdr_alt_master = f_alt; hdr_corr = f_corr;
        end
        @(negedge clk); hdr_valid = 0;
        if (has_ts) begin ts_valid = 1; ts_sec = f_sec; ts_ns = f_ns; end
        @(negedge clk); ts_valid = 0;
        if (do_eof) begin
            frm_eof = 1; eof_fcs_ok = f_fcs; eof_udp_ok = f_udp; eof_is_ip = f_ip;
        end
        if (wr) begin reg_wr_en = 1; reg_addr = wa; reg_wdata = wd; end
        @(negedge clk); frm_eof = 0; reg_wr_en = 0;
        eof_fcs_ok = 1; eof_udp_ok = 1; eof_is_ip = 1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_all("R1", 0, 0, 0, 0);
        // R2 direct writes, bit 30 of word 1 reads zero
        sw_write(2'd0, 32'h1111_1111);
        sw_write(2'd1, 32'h7FFF_FFFF);
        sw_write(2'd2, 32'h2222_2222);
        sw_write(2'd3, 32'h3333_3333);
        check_all("R2", 32'h1111_1111, 32'h3FFF_FFFF, 32'h2222_2222, 32'h3333_3333);
        // R4 good frame with auto clear
        f_sec = 32'h9; f_ns = 30'd9; f_corr = 64'h9;
        frame(1, 1, 1, 0, 0, 0);
        check_all("R4", 32'h1111_1111, 32'h3FFF_FFFF, 32'h2222_2222, 32'h3333_3333);
        // R3 enable auto and capture
        sw_write(2'd1, 32'h8000_0005);
        f_sec = 32'hA; f_ns = 30'd123; f_corr = 64'h0102_0304_0506_0708;
        frame(1, 1, 1, 0, 0, 0);
        check_all("R3", 32'hA, 32'h8000_007B, 32'h0102_0304, 32'h0506_0708);
        // R5 wrong message type
        f_msg = 4'h3; f_sec = 32'hB;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R5", 2'd0, 32'hA);
        f_msg = 4'h2;
        // R6 version check
        cfg_ver_chk_en = 1; cfg_version = 4'h2;
        f_ver = 4'h3; f_sec = 32'hC;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R6", 2'd0, 32'hA);
        f_ver = 4'h2; f_sec = 32'hD; f_ns = 30'd200; f_corr = 64'h1;
        frame(1, 1, 1, 0, 0, 0);
        check_all("R6", 32'hD, 32'h8000_00C8, 32'h0, 32'h1);
        cfg_ver_chk_en = 0; f_ver = 4'h1; f_sec = 32'hE;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R6", 2'd0, 32'hD);
        f_ver = 4'h2;
        // R7 domain check
        cfg_dom_chk_en = 1; cfg_domain = 8'h05;
        f_dom = 8'h04; f_sec = 32'hF;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R7", 2'd0, 32'hD);
        f_dom = 8'h05; f_sec = 32'h10; f_ns = 30'd300; f_corr = 64'h0;
        frame(1, 1, 1, 0, 0, 0);
        check_all("R7", 32'h10, 32'h8000_012C, 32'h0, 32'h0);
        // R8 alternate master check
        cfg_alt_chk_en = 1; cfg_alt_master = 0; f_alt = 1; f_sec = 32'h20;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R8", 2'd0, 32'h10);
        f_alt = 0;
        // R9 integrity checks
        cfg_fcs_chk_en = 1; f_fcs = 0; f_sec = 32'h21;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R9", 2'd0, 32'h10);
        f_fcs = 1; cfg_udp_chk_en = 1; f_udp = 0; f_ip = 1; f_sec = 32'h22;
        frame(1, 1, 1, 0, 0, 0);
        read_chk("R9", 2'd0, 32'h10);
        f_ip = 0; f_sec = 32'h11; f_ns = 30'd400;
        frame(1, 1, 1, 0, 0, 0);
        check_all("R9", 32'h11, 32'h8000_0190, 32'h0, 32'h0);
        f_udp = 1; f_ip = 1;
        // R10 missing timestamp, missing header
        f_sec = 32'h30;
        frame(1, 0, 1, 0, 0, 0);
        read_chk("R10", 2'd0, 32'h11);
        frame(0, 1, 1, 0, 0, 0);
        read_chk("R10", 2'd0, 32'h11);
        // R11 write in commit cycle is dropped, auto bit kept
        f_sec = 32'h12; f_ns = 30'd500; f_corr = 64'hAAAA_BBBB_CCCC_DDDD;
        frame(1, 1, 1, 1, 2'd1, 32'h0000_0000);
        check_all("R11", 32'h12, 32'h8000_01F4, 32'hAAAA_BBBB, 32'hCCCC_DDDD);
        // R12 aborted frame then new frame without header
        f_sec = 32'h40;
        frame(1, 1, 0, 0, 0, 0);
        f_sec = 32'h41;
        frame(0, 1, 1, 0, 0, 0);
        read_chk("R12", 2'd0, 32'h12);
        read_chk("R12", 2'd1, 32'h8000_01F4);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule